// File: doc/BRIEF.md
# Doubleword Load/Store Decode and Address Unit

This block takes one 32-bit instruction word at a time and recognises the doubleword memory instructions in their shifted-displacement and register-indexed forms, the update forms of both, the word-algebraic load, and the word store with update. When the instruction is valid, the block registers a memory request one cycle later. The request carries the effective address, a store flag, an access size in bytes, a sign-extend flag and the data register index. For update forms, the block also produces a base-register writeback of the same address.

Register file reads are performed outside the block. The block presents the two source register indices combinationally from the instruction word and takes the read values back on its input ports in the same cycle. Three kinds of word are refused with a one-cycle illegal pulse and no request: unknown opcodes, reserved extended values and forbidden update encodings.

Bit numbering used below: the primary opcode is `insn[31:26]`, the target/source field is `insn[25:21]`, the base field is `insn[20:16]` and the index field is `insn[15:11]`. The 14-bit displacement is `insn[15:2]` with its 2-bit selector in `insn[1:0]`. The 10-bit indexed extended opcode is `insn[10:1]`.

Top module: `dls_unit`

## Requirements
- R1: After reset and before any valid word, `reqValid`, `wbValid` and `illegal` are 0.
- R2: Primary opcode 58 with selector 0 is a doubleword load (size 8). Selector 1 is the doubleword load with update (size 8). Selector 2 is the word-algebraic load (size 4, `reqSignExt`=1). `reqSignExt` is 0 for every other operation.
- R3: Primary opcode 62 with selector 0 is a doubleword store, and selector 1 is a doubleword store with update. Both have size 8 and `reqStore`=1.
- R4: Under primary opcode 31, the extended opcodes are decoded as follows. 21 is an indexed doubleword load. 53 is the same load with update. 149 is an indexed doubleword store. 181 is that store with update. 183 is a word store with update (size 4). Stores have `reqStore`=1.
- R5: For displacement forms, `reqAddr` is the base plus the 14-bit displacement sign-extended and multiplied by 4. When the base field is 0 in a non-update form, the base is 0 instead of `raData`.
- R6: For indexed forms, `reqAddr` is the base plus `rbData`. When the base field is 0 in a non-update form, the base is 0.
- R7: For every accepted update form, `wbValid`=1 in the same cycle as `reqValid`, with `wbReg` equal to the base field and `wbData` equal to `reqAddr`. Non-update forms leave `wbValid`=0.
- R8: A load with update whose base field is 0, or whose base field equals its target field, is illegal. A store with update is illegal only when its base field is 0.
- R9: Any other valid word is illegal: an unknown primary opcode, an unknown indexed extended opcode, selector 3 under opcode 58, or selector 2 or 3 under opcode 62. When `illegal`=1, both `reqValid` and `wbValid` are 0.
- R10: Outputs appear one clock after a cycle with `inValid`=1. A cycle with `inValid`=0 yields `reqValid`, `wbValid` and `illegal` all 0 on the next cycle.
- R11: `raSel` equals `insn[20:16]` and `rbSel` equals `insn[15:11]` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Instruction word strobe |
| insn | input | 32 | Instruction word |
| raData | input | XLEN | Value read for the base register |
| rbData | input | XLEN | Value read for the index register |
| raSel | output | 5 | Base register read index |
| rbSel | output | 5 | Index register read index |
| reqValid | output | 1 | Memory request issued |
| reqStore | output | 1 | Request is a store |
| reqAddr | output | XLEN | Effective address |
| reqSize | output | 4 | Access size in bytes (8 or 4) |
| reqSignExt | output | 1 | Load result is sign-extended |
| reqDataReg | output | 5 | Target or source data register |
| wbValid | output | 1 | Base register writeback |
| wbReg | output | 5 | Writeback register index |
| wbData | output | XLEN | Writeback value |
| illegal | output | 1 | Word refused |

## Verification
The bench builds the unit with the default XLEN of 64. This width lets negative displacements sign-extend across the upper 48 bits. It also lets base plus offset wrap past the top of the address space, so both carry and sign propagation over the full word are checked against the reference. The random phase draws base and index values over the whole 64-bit range and mixes idle cycles with valid ones.

// File: rtl/dls_pkg.sv
package dls_pkg;
  localparam int INSN_W  = 32;
  localparam int REG_W   = 5;
  localparam int DISP_W  = 14;
  localparam int SIZE_W  = 4;
  localparam logic [5:0] OP_DSLOAD  = 6'd58;
  localparam logic [5:0] OP_DSSTORE = 6'd62;
  localparam logic [5:0] OP_INDEXED = 6'd31;
  localparam logic [9:0] XO_LDX   = 10'd21;
  localparam logic [9:0] XO_LDUX  = 10'd53;
  localparam logic [9:0] XO_STDX  = 10'd149;
  localparam logic [9:0] XO_STDUX = 10'd181;
  localparam logic [9:0] XO_STWUX = 10'd183;
  localparam logic [SIZE_W-1:0] SIZE_DWORD = 4'd8;
  localparam logic [SIZE_W-1:0] SIZE_WORD  = 4'd4;

  typedef struct packed {
    logic issue;
    logic store;
    logic indexed;
    logic zeroBase;
    logic update;
    logic word;
    logic signExt;
    logic refuse;
  } dlsCtrlT;
endpackage

// File: rtl/dls_ctrl.sv
module dls_ctrl
  import dls_pkg::*;
(
  input  logic              inValid,
  input  logic [INSN_W-1:0] insn,
  output dlsCtrlT           ctrl
);
  logic [5:0]       primOp;
  logic [1:0]       dsSel;
  logic [9:0]       extOp;
  logic [REG_W-1:0] tgtField;
  logic [REG_W-1:0] baseField;
  logic known, upd, st, idx, wordOp, sext, badUpdate;

  assign primOp    = insn[31:26];
  assign tgtField  = insn[25:21];
  assign baseField = insn[20:16];
  assign dsSel     = insn[1:0];
  assign extOp     = insn[10:1];

  always_comb begin
    known = 1'b0; upd = 1'b0; st = 1'b0; idx = 1'b0; wordOp = 1'b0; sext = 1'b0;
    unique case (primOp)
      OP_DSLOAD: begin
        case (dsSel)
          2'd0: known = 1'b1;
          2'd1: begin known = 1'b1; upd = 1'b1; end
          2'd2: begin known = 1'b1; wordOp = 1'b1; sext = 1'b1; end
          default: known = 1'b0;
        endcase
      end
      OP_DSSTORE: begin
        st = 1'b1;
        case (dsSel)
          2'd0: known = 1'b1;
          2'd1: begin known = 1'b1; upd = 1'b1; end
          default: known = 1'b0;
        endcase
      end
      OP_INDEXED: begin
        idx = 1'b1;
        case (extOp)
          XO_LDX:   known = 1'b1;
          XO_LDUX:  begin known = 1'b1; upd = 1'b1; end
          XO_STDX:  begin known = 1'b1; st = 1'b1; end
          XO_STDUX: begin known = 1'b1; st = 1'b1; upd = 1'b1; end
          XO_STWUX: begin known = 1'b1; st = 1'b1; upd = 1'b1; wordOp = 1'b1; end
          default:  known = 1'b0;
        endcase
      end
      default: known = 1'b0;
    endcase
  end

  assign badUpdate = upd && ((baseField == '0) || (!st && (baseField == tgtField)));

  always_comb begin
    ctrl          = '0;
    ctrl.issue    = inValid && known && !badUpdate;
    ctrl.refuse   = inValid && (!known || badUpdate);
    ctrl.store    = st;
    ctrl.indexed  = idx;
    ctrl.update   = upd;
    ctrl.zeroBase = !upd && (baseField == '0);
    ctrl.word     = wordOp;
    ctrl.signExt  = sext;
  end
endmodule

// File: rtl/dls_datapath.sv
module dls_datapath
  import dls_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dlsCtrlT           ctrl,
  input  logic [INSN_W-1:0] insn,
  input  logic [XLEN-1:0]   raData,
  input  logic [XLEN-1:0]   rbData,
  output logic              reqValid,
  output logic              reqStore,
  output logic [XLEN-1:0]   reqAddr,
  output logic [SIZE_W-1:0] reqSize,
  output logic              reqSignExt,
  output logic [REG_W-1:0]  reqDataReg,
  output logic              wbValid,
  output logic [REG_W-1:0]  wbReg,
  output logic [XLEN-1:0]   wbData,
  output logic              illegal
);
  localparam int EXT_W = XLEN - DISP_W - 2;

  logic [DISP_W-1:0] dispField;
  logic [XLEN-1:0]   dispOffset;
  logic [XLEN-1:0]   baseVal;
  logic [XLEN-1:0]   offsetVal;
  logic [XLEN-1:0]   effAddr;

  assign dispField  = insn[15:2];
  assign dispOffset = {{EXT_W{dispField[DISP_W-1]}}, dispField, 2'b00};
  assign baseVal    = ctrl.zeroBase ? '0 : raData;
  assign offsetVal  = ctrl.indexed ? rbData : dispOffset;
  assign effAddr    = baseVal + offsetVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqValid   <= 1'b0;
      wbValid    <= 1'b0;
      illegal    <= 1'b0;
      reqStore   <= 1'b0;
      reqAddr    <= '0;
      reqSize    <= '0;
      reqSignExt <= 1'b0;
      reqDataReg <= '0;
      wbReg      <= '0;
      wbData     <= '0;
    end else begin
      reqValid <= ctrl.issue;
      wbValid  <= ctrl.issue && ctrl.update;
      illegal  <= ctrl.refuse;
      if (ctrl.issue) begin
        reqStore   <= ctrl.store;
        reqAddr    <= effAddr;
        reqSize    <= ctrl.word ? SIZE_WORD : SIZE_DWORD;
        reqSignExt <= ctrl.signExt;
        reqDataReg <= insn[25:21];
        wbReg      <= insn[20:16];
        wbData     <= effAddr;
      end
    end
  end
endmodule

// File: rtl/dls_unit.sv
module dls_unit
  import dls_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [INSN_W-1:0] insn,
  input  logic [XLEN-1:0]   raData,
  input  logic [XLEN-1:0]   rbData,
  output logic [REG_W-1:0]  raSel,
  output logic [REG_W-1:0]  rbSel,
  output logic              reqValid,
  output logic              reqStore,
  output logic [XLEN-1:0]   reqAddr,
  output logic [SIZE_W-1:0] reqSize,
  output logic              reqSignExt,
  output logic [REG_W-1:0]  reqDataReg,
  output logic              wbValid,
  output logic [REG_W-1:0]  wbReg,
  output logic [XLEN-1:0]   wbData,
  output logic              illegal
);
  dlsCtrlT ctrl;

  assign raSel = insn[20:16];
  assign rbSel = insn[15:11];

  dls_ctrl ctrl_i (
    .inValid (inValid),
    .insn    (insn),
    .ctrl    (ctrl)
  );

  dls_datapath #(.XLEN(XLEN)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .insn       (insn),
    .raData     (raData),
    .rbData     (rbData),
    .reqValid   (reqValid),
    .reqStore   (reqStore),
    .reqAddr    (reqAddr),
    .reqSize    (reqSize),
    .reqSignExt (reqSignExt),
    .reqDataReg (reqDataReg),
    .wbValid    (wbValid),
    .wbReg      (wbReg),
    .wbData     (wbData),
    .illegal    (illegal)
  );
endmodule

// File: rtl/dls_unit_chk.sv
module dls_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            inValid,
  input logic [31:0]     insn,
  input logic            reqValid,
  input logic            reqStore,
  input logic [XLEN-1:0] reqAddr,
  input logic [3:0]      reqSize,
  input logic            reqSignExt,
  input logic            wbValid,
  input logic [4:0]      wbReg,
  input logic [XLEN-1:0] wbData,
  input logic            illegal
);
  p_refuse_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!reqValid && !wbValid));

  p_wb_mirror_r7: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (reqValid && wbData == reqAddr));

  p_wb_base_r8: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> (wbReg != 5'd0));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> (!reqValid && !wbValid && !illegal));

  p_sext_word_r2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSignExt) |-> (reqSize == 4'd4 && !reqStore));

  p_word_store_upd_r4: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqStore && reqSize == 4'd4) |-> wbValid);

  p_size_legal_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqSize == 4'd8 || reqSize == 4'd4));
endmodule

bind dls_unit dls_unit_chk #(.XLEN(XLEN)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .insn       (insn),
  .reqValid   (reqValid),
  .reqStore   (reqStore),
  .reqAddr    (reqAddr),
  .reqSize    (reqSize),
  .reqSignExt (reqSignExt),
  .wbValid    (wbValid),
  .wbReg      (wbReg),
  .wbData     (wbData),
  .illegal    (illegal)
);

// File: tb/dls_unit_tb_top.sv
module dls_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] insn = '0;
  logic [63:0] raData = '0;
  logic [63:0] rbData = '0;
  logic [4:0]  raSel, rbSel, reqDataReg, wbReg;
  logic        reqValid, reqStore, reqSignExt, wbValid, illegal;
  logic [63:0] reqAddr, wbData;
  logic [3:0]  reqSize;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // expected outputs for the next sample
  string       eTag = "R1";
  logic        eV = 0, eS = 0, eX = 0, eW = 0, eI = 0;
  logic [63:0] eA = '0, eWD = '0;
  logic [3:0]  eZ = '0;
  logic [4:0]  eD = '0, eWR = '0;

  always #5 clk = ~clk;

  dls_unit #(.XLEN(64)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .insn(insn),
    .raData(raData), .rbData(rbData), .raSel(raSel), .rbSel(rbSel),
    .reqValid(reqValid), .reqStore(reqStore), .reqAddr(reqAddr),
    .reqSize(reqSize), .reqSignExt(reqSignExt), .reqDataReg(reqDataReg),
    .wbValid(wbValid), .wbReg(wbReg), .wbData(wbData), .illegal(illegal)
  );

  function automatic logic [31:0] dsWord(int po, int rt, int ra, int disp, int sel);
    logic [13:0] d = 14'(disp);
    return {6'(po), 5'(rt), 5'(ra), d, 2'(sel)};
  endfunction

  function automatic logic [31:0] xWord(int rt, int ra, int rb, int xo);
    return {6'd31, 5'(rt), 5'(ra), 5'(rb), 10'(xo), 1'b0};
  endfunction

  task automatic model(input logic v, input logic [31:0] i, input logic [63:0] a, input logic [63:0] b);
    int po, rt, rA, xs, xl;
    bit known, upd, st, idx, bad;
    logic [63:0] base, off;
    eV = 0; eS = 0; eX = 0; eW = 0; eI = 0; eA = '0; eWD = '0; eZ = 4'd8; eD = '0; eWR = '0;
    if (!v) return;
    po = int'(i[31:26]); rt = int'(i[25:21]); rA = int'(i[20:16]);
    xs = int'(i[1:0]); xl = int'(i[10:1]);
    known = 0; upd = 0; st = 0; idx = 0;
    if (po == 58) begin
      if (xs == 0) known = 1;
      if (xs == 1) begin known = 1; upd = 1; end
      if (xs == 2) begin known = 1; eZ = 4'd4; eX = 1; end
    end else if (po == 62) begin
      st = 1;
      if (xs == 0) known = 1;
      if (xs == 1) begin known = 1; upd = 1; end
    end else if (po == 31) begin
      idx = 1;
      if (xl == 21) known = 1;
      if (xl == 53) begin known = 1; upd = 1; end
      if (xl == 149) begin known = 1; st = 1; end
      if (xl == 181) begin known = 1; st = 1; upd = 1; end
      if (xl == 183) begin known = 1; st = 1; upd = 1; eZ = 4'd4; end
    end
    bad = upd && (rA == 0 || (!st && rA == rt));
    if (!known || bad) begin
      eI = 1; eX = 0;
      return;
    end
    base = (rA == 0 && !upd) ? 64'd0 : a;
    off  = idx ? b : 64'(longint'($signed(i[15:2])) * 4);
    eA = base + off;
    eV = 1; eS = st; eD = 5'(rt);
    if (upd) begin eW = 1; eWR = 5'(rA); eWD = eA; end
  endtask

  task automatic compare();
    bit bad;
    bad = (reqValid !== eV) || (wbValid !== eW) || (illegal !== eI);
    if (eV) bad = bad || (reqStore !== eS) || (reqAddr !== eA) || (reqSize !== eZ)
                      || (reqSignExt !== eX) || (reqDataReg !== eD);
    if (eW) bad = bad || (wbReg !== eWR) || (wbData !== eWD);
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s: got v=%b s=%b a=%h z=%0d x=%b d=%0d w=%b wr=%0d wd=%h i=%b exp v=%b s=%b a=%h z=%0d x=%b d=%0d w=%b wr=%0d wd=%h i=%b",
        eTag, reqValid, reqStore, reqAddr, reqSize, reqSignExt, reqDataReg, wbValid, wbReg, wbData, illegal,
        eV, eS, eA, eZ, eX, eD, eW, eWR, eWD, eI);
    end
  endtask

  task automatic step(input string tag, input logic v, input logic [31:0] i,
                      input logic [63:0] a, input logic [63:0] b);
    @(negedge clk);
    compare();
    inValid = v; insn = i; raData = a; rbData = b;
    model(v, i, a, b);
    eTag = tag;
    #1;
    checks++;
    if (raSel !== i[20:16] || rbSel !== i[15:11]) begin
      errors++;
      $display("FAIL R11: got ra=%0d rb=%0d exp ra=%0d rb=%0d", raSel, rbSel, i[20:16], i[15:11]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state checked by the first compare
    step("R1", 0, '0, '0, '0);
    // R2 opcode 58 family
    step("R2", 1, dsWord(58, 7, 3, 5, 0), 64'h1000, 0);
    step("R2", 1, dsWord(58, 5, 4, -3, 1), 64'h2000, 0);
    step("R2", 1, dsWord(58, 9, 0, 100, 2), 64'hDEAD, 0);
    step("R2", 1, dsWord(58, 9, 6, 8, 2), 64'h40, 0);
    // R3 opcode 62 family
    step("R3", 1, dsWord(62, 2, 8, 16, 0), 64'h500, 0);
    step("R3", 1, dsWord(62, 8, 8, -1, 1), 64'h500, 0);
    // R4 indexed family
    step("R4", 1, xWord(1, 2, 3, 21), 64'h100, 64'h23);
    step("R4", 1, xWord(1, 2, 3, 53), 64'h100, 64'h23);
    step("R4", 1, xWord(4, 5, 6, 149), 64'h7000, 64'hFFFF_FFFF_FFFF_FFF0);
    step("R4", 1, xWord(4, 5, 6, 181), 64'h7000, 64'h8);
    step("R4", 1, xWord(4, 5, 6, 183), 64'h7000, 64'h4);
    // R5 displacement boundaries
    step("R5", 1, dsWord(58, 3, 0, -8192, 0), 64'hFFFF, 0);
    step("R5", 1, dsWord(58, 3, 1, 8191, 0), 64'hFFFF_FFFF_FFFF_FFFF, 0);
    step("R5", 1, dsWord(62, 3, 0, 1, 0), 64'h1234, 0);
    // R6 indexed base handling
    step("R6", 1, xWord(7, 0, 9, 21), 64'hABCD, 64'h88);
    step("R6", 1, xWord(7, 0, 9, 149), 64'hABCD, 64'h88);
    step("R6", 1, xWord(7, 12, 9, 53), 64'hFFFF_FFFF_FFFF_FFF8, 64'h10);
    // R7 writeback
    step("R7", 1, dsWord(62, 31, 31, 2, 1), 64'h80, 0);
    step("R7", 1, dsWord(58, 1, 30, 4, 1), 64'h80, 0);
    // R8 update validity
    step("R8", 1, dsWord(58, 5, 0, 4, 1), 64'h80, 0);
    step("R8", 1, dsWord(58, 5, 5, 4, 1), 64'h80, 0);
    step("R8", 1, dsWord(62, 5, 5, 4, 1), 64'h80, 0);
    step("R8", 1, dsWord(62, 5, 0, 4, 1), 64'h80, 0);
    step("R8", 1, xWord(6, 6, 2, 53), 64'h80, 1);
    step("R8", 1, xWord(6, 6, 2, 181), 64'h80, 1);
    step("R8", 1, xWord(6, 0, 2, 183), 64'h80, 1);
    // R9 reserved and unknown words
    step("R9", 1, dsWord(58, 1, 2, 3, 3), 64'h80, 0);
    step("R9", 1, dsWord(62, 1, 2, 3, 2), 64'h80, 0);
    step("R9", 1, dsWord(62, 1, 2, 3, 3), 64'h80, 0);
    step("R9", 1, dsWord(14, 1, 2, 3, 0), 64'h80, 0);
    step("R9", 1, xWord(1, 2, 3, 23), 64'h80, 0);
    // R10 idle cycles after activity
    step("R10", 0, dsWord(58, 7, 3, 5, 0), 64'h1000, 0);
    step("R10", 0, xWord(1, 0, 2, 999), 0, 0);
    for (int n = 0; n < 400; n++) begin
      int k;
      logic [31:0] w;
      k = $urandom_range(0, 9);
      case (k)
        0: w = dsWord(58, $urandom_range(0, 31), $urandom_range(0, 31), $urandom, $urandom_range(0, 3));
        1: w = dsWord(62, $urandom_range(0, 31), $urandom_range(0, 31), $urandom, $urandom_range(0, 3));
        2: w = xWord($urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31), 21);
        3: w = xWord($urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31), 53);
        4: w = xWord($urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31), 149);
        5: w = xWord($urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31), 181);
        6: w = xWord($urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31), 183);
        7: w = xWord($urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 31), $urandom_range(0, 1023));
        8: w = dsWord(58, 3, 3, $urandom, 1);
        default: w = $urandom;
      endcase
      step("R10", ($urandom_range(0, 3) != 0), w, {$urandom, $urandom}, {$urandom, $urandom});
    end
    step("R10", 0, '0, '0, '0);
    step("R10", 0, '0, '0, '0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got running exp finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule